// File: doc/BRIEF.md
# Interrupt Priority Resolution Unit

This block looks at every interrupt request pending in a cycle and names one winner. Six request classes have a fixed rank in hardware: reset, non-maskable, debug, watchdog, single step and address match. A group of maskable peripheral requests sits between the watchdog class and the single-step class. Each peripheral source has a 3-bit priority level that software writes. Inside the group the highest programmed level wins. When levels are equal, the fixed hardware rank decides, and the lowest index ranks highest.

A peripheral source takes part only when the global enable is set and its level is strictly above the processor's current priority level. Level 0 means the source is off. The fixed classes ignore both the enable and the processor level.

The winner is resolved combinationally and latched into output registers. A latched grant stays unchanged until the consumer acknowledges it. The one exception is a reset request, which replaces the held grant. Software trap instructions are not arbitrated here.

Top module: `irq_arbiter`

## Requirements
- R1: A synchronous `rst` clears every peripheral level register to 0 and drives `grant_vld` to 0 at the next edge.
- R2: The class ranking is fixed, from highest to lowest: reset (code 0), non-maskable (1), debug (2), watchdog (3), peripheral group (4), single step (5), address match (6). Only the top-ranked pending class is granted, and it is reported on `grant_cls` using these codes.
- R3: A pending `req_reset` is granted at the next edge in every state, including while another grant is held.
- R4: A peripheral request competes only when `int_en` is 1 and its level is strictly greater than `cpu_ipl`. The fixed classes compete regardless of `int_en` and `cpu_ipl`.
- R5: A peripheral source whose level is 0 never wins.
- R6: Among the peripheral requests that compete, the one with the highest programmed level wins.
- R7: Among competing peripheral requests with equal levels, the lowest index wins.
- R8: When `lvl_we` is 1 at an edge, `lvl_wdata` is stored as the level of source `lvl_wsel`. Arbitration at that same edge still uses the old level; the new level is used from the following edge.
- R9: When `grant_vld` is 0 and some request competes, the winner is registered at the next edge. For a peripheral winner, `grant_idx` carries its index and `grant_lvl` its level. For a fixed-class winner, `grant_idx` is 0 and `grant_lvl` is all ones.
- R10: While `grant_vld` is 1 and `ack` is 0, with no reset request, `grant_cls`, `grant_idx` and `grant_lvl` hold their values whatever the requests do.
- R11: When `grant_vld` and `ack` are both 1 at an edge (with no reset request), `grant_vld` falls. Arbitration resumes at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lvl_we | input | 1 | Write strobe for a peripheral level register |
| lvl_wsel | input | IDX_W | Peripheral source whose level is written |
| lvl_wdata | input | LVL_W | Level value to write |
| req_reset | input | 1 | Reset-class request |
| req_nmi | input | 1 | Non-maskable request |
| req_debug | input | 1 | Debug request |
| req_wdt | input | 1 | Watchdog request |
| req_step | input | 1 | Single-step request |
| req_amatch | input | 1 | Address-match request |
| periph_req | input | N_SRC | Maskable peripheral requests |
| cpu_ipl | input | LVL_W | Current processor interrupt priority level |
| int_en | input | 1 | Global maskable interrupt enable |
| ack | input | 1 | Consumer accepts the presented grant |
| grant_vld | output | 1 | A grant is presented |
| grant_cls | output | 3 | Class code of the winner |
| grant_idx | output | IDX_W | Peripheral index of the winner |
| grant_lvl | output | LVL_W | Level of the winner |

## Verification
A corrupted level register shows up only when its source competes against another source. The outcome is then a wrong index or a missing grant, one edge after the requests are presented. For this reason the stimulus programs levels that collide on purpose and then moves `cpu_ipl` across them. A broken hold or acknowledge path shows within one cycle, as a grant that changes, stays up, or comes back while the consumer is still holding. A behavioural model checks every clock, so any of these differences is reported in the cycle it first appears.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int CLS_W = 3;
  typedef enum logic [CLS_W-1:0] {
    CLS_RESET  = 3'd0,
    CLS_NMI    = 3'd1,
    CLS_DEBUG  = 3'd2,
    CLS_WDT    = 3'd3,
    CLS_PERIPH = 3'd4,
    CLS_STEP   = 3'd5,
    CLS_AMATCH = 3'd6
  } irq_cls_e;
endpackage

// File: rtl/irq_lvl_regs.sv
module irq_lvl_regs #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [IDX_W-1:0]       wsel,
  input  logic [LVL_W-1:0]       wdata,
  output logic [N_SRC*LVL_W-1:0] lvl_flat
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_reg
    logic [LVL_W-1:0] lvl_q;
    always_ff @(posedge clk) begin
      if (rst)
        lvl_q <= '0;
      else if (we && (wsel == IDX_W'(g)))
        lvl_q <= wdata;
    end
    assign lvl_flat[g*LVL_W +: LVL_W] = lvl_q;
  end
endmodule

// File: rtl/irq_periph_pick.sv
module irq_periph_pick #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]       req,
  input  logic [N_SRC*LVL_W-1:0] lvl_flat,
  input  logic [LVL_W-1:0]       cpu_ipl,
  input  logic                   int_en,
  output logic                   found,
  output logic [IDX_W-1:0]       win_idx,
  output logic [LVL_W-1:0]       win_lvl
);
  logic [N_SRC-1:0] elig;

  for (genvar g = 0; g < N_SRC; g++) begin : g_elig
    logic [LVL_W-1:0] lv;
    assign lv      = lvl_flat[g*LVL_W +: LVL_W];
    assign elig[g] = req[g] && int_en && (lv != '0) && (lv > cpu_ipl);
  end

  // Scan from the highest index down; ">=" lets a lower index take over a tie.
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i] && (lvl_flat[i*LVL_W +: LVL_W] >= win_lvl)) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = lvl_flat[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/irq_class_sel.sv
module irq_class_sel
  import irq_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             req_reset,
  input  logic             req_nmi,
  input  logic             req_debug,
  input  logic             req_wdt,
  input  logic             req_step,
  input  logic             req_amatch,
  input  logic             p_found,
  input  logic [IDX_W-1:0] p_idx,
  input  logic [LVL_W-1:0] p_lvl,
  output logic             any,
  output irq_cls_e         cls,
  output logic [IDX_W-1:0] idx,
  output logic [LVL_W-1:0] lvl
);
  always_comb begin
    any = 1'b1;
    cls = CLS_RESET;
    idx = '0;
    lvl = '1;
    if      (req_reset)  cls = CLS_RESET;
    else if (req_nmi)    cls = CLS_NMI;
    else if (req_debug)  cls = CLS_DEBUG;
    else if (req_wdt)    cls = CLS_WDT;
    else if (p_found) begin
      cls = CLS_PERIPH;
      idx = p_idx;
      lvl = p_lvl;
    end
    else if (req_step)   cls = CLS_STEP;
    else if (req_amatch) cls = CLS_AMATCH;
    else                 any = 1'b0;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl_we,
  input  logic [IDX_W-1:0] lvl_wsel,
  input  logic [LVL_W-1:0] lvl_wdata,
  input  logic             req_reset,
  input  logic             req_nmi,
  input  logic             req_debug,
  input  logic             req_wdt,
  input  logic             req_step,
  input  logic             req_amatch,
  input  logic [N_SRC-1:0] periph_req,
  input  logic [LVL_W-1:0] cpu_ipl,
  input  logic             int_en,
  input  logic             ack,
  output logic             grant_vld,
  output logic [CLS_W-1:0] grant_cls,
  output logic [IDX_W-1:0] grant_idx,
  output logic [LVL_W-1:0] grant_lvl
);
  logic [N_SRC*LVL_W-1:0] lvl_flat;
  logic                   p_found;
  logic [IDX_W-1:0]       p_idx;
  logic [LVL_W-1:0]       p_lvl;
  logic                   w_any;
  irq_cls_e               w_cls;
  logic [IDX_W-1:0]       w_idx;
  logic [LVL_W-1:0]       w_lvl;

  irq_lvl_regs #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst(rst), .we(lvl_we), .wsel(lvl_wsel),
    .wdata(lvl_wdata), .lvl_flat(lvl_flat)
  );

  irq_periph_pick #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_pick (
    .req(periph_req), .lvl_flat(lvl_flat), .cpu_ipl(cpu_ipl),
    .int_en(int_en), .found(p_found), .win_idx(p_idx), .win_lvl(p_lvl)
  );

  irq_class_sel #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_sel (
    .req_reset(req_reset), .req_nmi(req_nmi), .req_debug(req_debug),
    .req_wdt(req_wdt), .req_step(req_step), .req_amatch(req_amatch),
    .p_found(p_found), .p_idx(p_idx), .p_lvl(p_lvl),
    .any(w_any), .cls(w_cls), .idx(w_idx), .lvl(w_lvl)
  );

  logic load;
  assign load = req_reset || (!grant_vld && w_any);

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_vld <= 1'b0;
      grant_cls <= '0;
      grant_idx <= '0;
      grant_lvl <= '0;
    end else if (load) begin
      grant_vld <= 1'b1;
      grant_cls <= w_cls;
      grant_idx <= w_idx;
      grant_lvl <= w_lvl;
    end else if (grant_vld && ack) begin
      grant_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
  import irq_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             req_reset,
  input logic             req_nmi,
  input logic             req_debug,
  input logic             req_wdt,
  input logic [LVL_W-1:0] cpu_ipl,
  input logic             int_en,
  input logic             ack,
  input logic             grant_vld,
  input logic [CLS_W-1:0] grant_cls,
  input logic [IDX_W-1:0] grant_idx,
  input logic [LVL_W-1:0] grant_lvl
);
  p_rst_clears_r1: assert property (@(posedge clk) rst |=> !grant_vld);

  p_reset_wins_r3: assert property (@(posedge clk) disable iff (rst)
    req_reset |=> (grant_vld && grant_cls == CLS_RESET));

  p_nmi_over_rest_r2: assert property (@(posedge clk) disable iff (rst)
    (!grant_vld && !req_reset && req_nmi) |=> (grant_vld && grant_cls == CLS_NMI));

  p_periph_gate_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(grant_vld) && grant_cls == CLS_PERIPH) |->
      ($past(int_en) && grant_lvl > $past(cpu_ipl)));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (grant_vld && !ack && !req_reset) |=>
      (grant_vld && $stable(grant_cls) && $stable(grant_idx) && $stable(grant_lvl)));

  p_ack_drop_r11: assert property (@(posedge clk) disable iff (rst)
    (grant_vld && ack && !req_reset) |=> !grant_vld);

  p_fixed_lvl_r9: assert property (@(posedge clk) disable iff (rst)
    (grant_vld && grant_cls != CLS_PERIPH) |-> (grant_idx == '0 && grant_lvl == '1));
endmodule

bind irq_arbiter irq_arbiter_chk #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .req_reset(req_reset), .req_nmi(req_nmi),
  .req_debug(req_debug), .req_wdt(req_wdt), .cpu_ipl(cpu_ipl),
  .int_en(int_en), .ack(ack), .grant_vld(grant_vld), .grant_cls(grant_cls),
  .grant_idx(grant_idx), .grant_lvl(grant_lvl)
);

// File: tb/sim_irq_arbiter.sv
`timescale 1ns/1ps
module sim_irq_arbiter;
  localparam int N = 8;
  localparam int LW = 3;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lvl_we = 1'b0;
  logic [IW-1:0] lvl_wsel = '0;
  logic [LW-1:0] lvl_wdata = '0;
  logic req_reset = 0, req_nmi = 0, req_debug = 0, req_wdt = 0, req_step = 0, req_amatch = 0;
  logic [N-1:0] periph_req = '0;
  logic [LW-1:0] cpu_ipl = '0;
  logic int_en = 1'b0;
  logic ack = 1'b0;
  logic grant_vld;
  logic [2:0] grant_cls;
  logic [IW-1:0] grant_idx;
  logic [LW-1:0] grant_lvl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_arbiter #(.N_SRC(N), .LVL_W(LW)) u0 (
    .clk(clk), .rst(rst), .lvl_we(lvl_we), .lvl_wsel(lvl_wsel), .lvl_wdata(lvl_wdata),
    .req_reset(req_reset), .req_nmi(req_nmi), .req_debug(req_debug), .req_wdt(req_wdt),
    .req_step(req_step), .req_amatch(req_amatch), .periph_req(periph_req),
    .cpu_ipl(cpu_ipl), .int_en(int_en), .ack(ack), .grant_vld(grant_vld),
    .grant_cls(grant_cls), .grant_idx(grant_idx), .grant_lvl(grant_lvl)
  );

  // Behavioural reference model
  int m_lvl [N];
  int m_vld = 0, m_cls = 0, m_idx = 0, m_lv = 0;

  always @(posedge clk) begin
    int wc, wi, wl;
    bit hit;
    if (rst) begin
      for (int i = 0; i < N; i++) m_lvl[i] = 0;
      m_vld = 0; m_cls = 0; m_idx = 0; m_lv = 0;
    end else begin
      hit = 0; wc = 0; wi = 0; wl = 7;
      if (req_reset)      begin hit = 1; wc = 0; end
      else if (req_nmi)   begin hit = 1; wc = 1; end
      else if (req_debug) begin hit = 1; wc = 2; end
      else if (req_wdt)   begin hit = 1; wc = 3; end
      else begin
        for (int l = 7; l >= 1 && !hit; l--)
          for (int i = 0; i < N && !hit; i++)
            if (int_en && periph_req[i] && m_lvl[i] == l && l > int'(cpu_ipl)) begin
              hit = 1; wc = 4; wi = i; wl = l;
            end
        if (!hit && req_step)        begin hit = 1; wc = 5; end
        else if (!hit && req_amatch) begin hit = 1; wc = 6; end
      end
      if (req_reset || (!m_vld && hit)) begin
        m_vld = 1; m_cls = wc; m_idx = wi; m_lv = wl;
      end else if (m_vld && ack) m_vld = 0;
      if (lvl_we) m_lvl[lvl_wsel] = int'(lvl_wdata);
    end
  end

  always @(posedge clk) begin
    #1;
    if (!done) begin
      checks++;
      if (int'(grant_vld) != m_vld ||
          (m_vld && (int'(grant_cls) != m_cls || int'(grant_idx) != m_idx || int'(grant_lvl) != m_lv))) begin
        errors++;
        $display("FAIL MODEL t=%0t actual vld=%0d cls=%0d idx=%0d lvl=%0d expected vld=%0d cls=%0d idx=%0d lvl=%0d",
                 $time, grant_vld, grant_cls, grant_idx, grant_lvl, m_vld, m_cls, m_idx, m_lv);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_grant(string tag, int cls, int idx, int lv);
    chk({tag, " vld"}, int'(grant_vld), 1);
    chk({tag, " cls"}, int'(grant_cls), cls);
    chk({tag, " idx"}, int'(grant_idx), idx);
    chk({tag, " lvl"}, int'(grant_lvl), lv);
  endtask

  task automatic wr(int s, int v);
    lvl_we = 1; lvl_wsel = IW'(s); lvl_wdata = LW'(v);
    tick();
    lvl_we = 0;
  endtask

  task automatic consume();
    ack = 1; tick(); ack = 0;
    chk("R11 drop", int'(grant_vld), 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(); tick();
    chk("R1 reset vld", int'(grant_vld), 0);
    rst = 0;
    wr(0, 2); wr(3, 5); wr(5, 5); wr(6, 0);
    int_en = 1; cpu_ipl = 0;
    periph_req = 8'b0010_1001;
    tick();
    chk_grant("R6 R7 tie", 4, 3, 5);
    periph_req = 8'b0000_0001;
    tick();
    chk_grant("R10 hold", 4, 3, 5);
    consume();
    tick();
    chk_grant("R11 rearb", 4, 0, 2);
    periph_req = '0; consume();
    periph_req = 8'b0000_0001; cpu_ipl = 2;
    tick();
    chk("R4 ipl gate", int'(grant_vld), 0);
    cpu_ipl = 1;
    tick();
    chk_grant("R4 above ipl", 4, 0, 2);
    periph_req = '0; consume();
    cpu_ipl = 0; int_en = 0; periph_req = 8'b0000_1000;
    tick();
    chk("R4 int_en off", int'(grant_vld), 0);
    int_en = 1; periph_req = 8'b0100_0000;
    tick();
    chk("R5 level zero", int'(grant_vld), 0);
    periph_req = 8'b0000_0001; req_step = 1; req_amatch = 1;
    tick();
    chk_grant("R2 periph over step", 4, 0, 2);
    periph_req = '0; consume();
    tick();
    chk_grant("R2 step over amatch", 5, 0, 7);
    req_step = 0; consume();
    tick();
    chk_grant("R9 amatch fixed lvl", 6, 0, 7);
    req_amatch = 0; consume();
    int_en = 0; req_nmi = 1; req_debug = 1; req_wdt = 1;
    tick();
    chk_grant("R2 R4 nmi first", 1, 0, 7);
    req_nmi = 0; consume();
    tick();
    chk_grant("R2 debug next", 2, 0, 7);
    req_debug = 0; consume();
    tick();
    chk_grant("R2 wdt next", 3, 0, 7);
    req_wdt = 0; consume();
    int_en = 1; periph_req = 8'b0000_0010;
    lvl_we = 1; lvl_wsel = 1; lvl_wdata = 6;
    tick();
    lvl_we = 0;
    chk("R8 old level used", int'(grant_vld), 0);
    tick();
    chk_grant("R8 new level", 4, 1, 6);
    req_reset = 1;
    tick();
    chk_grant("R3 reset preempts", 0, 0, 7);
    req_reset = 0; periph_req = '0; consume();
    rst = 1; tick(); rst = 0;
    chk("R1 rst vld", int'(grant_vld), 0);
    periph_req = 8'b0010_1011;
    tick();
    chk("R1 levels cleared", int'(grant_vld), 0);
    periph_req = '0;
    tick();
    finish_run();
  end
endmodule